// File: doc/BRIEF.md
# Diagnostic Threshold Alarm Flag Generator

This block watches five live monitor readings of an optical link module: internal temperature, supply voltage, laser bias current, transmitted optical power and received optical power. It compares each of them against four programmable limits (an upper alarm, a lower alarm, an upper warning and a lower warning) and packs the results into two alarm flag bytes and two warning flag bytes for a host to read. Analog sampling, calibration and the serial management bus sit outside this block.

The limits live in a 40-byte register file that is loaded one byte per cycle through a plain write port. Every limit is 16 bits wide and is held as two adjacent bytes, most significant byte first. The readings arrive together as one set of 16-bit samples with a single valid strobe. Each strobe recomputes all flags. Between strobes the flags keep their value. Temperature is a signed two's complement quantity in 1/256 degree steps. The other four readings are unsigned magnitudes: voltage in 100 µV steps, bias in 2 µA steps, and both powers in 0.1 µW steps.

Top module: `dmon_flag_gen`

## Requirements
- R1: A synchronous active-high reset sets all four flag bytes to 0x00.
- R2: A limit byte at write address A = 8*ch + 2*kind + half is stored, where ch is the channel index (0 temperature, 1 supply voltage, 2 bias, 3 transmit power, 4 receive power), kind is the limit kind (0 upper alarm, 1 lower alarm, 2 upper warning, 3 lower warning) and half is 0 for bits 15..8 and 1 for bits 7..0. Writes to addresses 40 to 63 change nothing.
- R3: An upper flag is set only when the reading is strictly greater than its upper limit. A reading equal to the limit leaves the flag clear.
- R4: A lower flag is set only when the reading is strictly less than its lower limit. A reading equal to the limit leaves the flag clear.
- R5: The temperature reading and its limits are compared as signed two's complement values. For example, 0xFF00 (-1 degree) lies below an upper limit of 0x5500.
- R6: The supply voltage, bias, transmit power and receive power readings are compared as unsigned values. For example, 0xFF00 lies above an upper limit of 0x9088.
- R7: The first alarm byte holds the upper and lower flags of temperature in bits 7 and 6, supply voltage in bits 5 and 4, bias in bits 3 and 2, and transmit power in bits 1 and 0.
- R8: The second alarm byte holds the receive power upper flag in bit 7 and its lower flag in bit 6. Bits 5..0 read as zero.
- R9: The two warning bytes use the layout of R7 and R8, driven by the upper and lower warning limits.
- R10: The flags change only on the clock edge at which the sample valid strobe is high. The result is visible one cycle later. Without a strobe they hold, whatever the reading inputs do.
- R11: A limit write in the same cycle as a strobe does not affect that strobe's result. It does affect every later strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lim_wr_en | input | 1 | Limit byte write enable |
| lim_wr_addr | input | 6 | Limit byte address (R2) |
| lim_wr_data | input | 8 | Limit byte value |
| smp_valid | input | 1 | Sample set strobe |
| smp_temp | input | 16 | Temperature reading, signed |
| smp_vcc | input | 16 | Supply voltage reading |
| smp_bias | input | 16 | Laser bias reading |
| smp_txpwr | input | 16 | Transmit power reading |
| smp_rxpwr | input | 16 | Receive power reading |
| alarm_flags0 | output | 8 | First alarm byte (R7) |
| alarm_flags1 | output | 8 | Second alarm byte (R8) |
| warn_flags0 | output | 8 | First warning byte (R9) |
| warn_flags1 | output | 8 | Second warning byte (R9) |

## Verification
The hardest case to reach from the ports is a limit write that lands on the same clock edge as a sample strobe. Here the old limit must decide the result and the new limit must decide only the next result. The bench drives the write enable and the strobe in the same cycle. The write lowers the temperature upper alarm below the current reading. The bench expects the flags to stay clear on that strobe and the alarm to appear on the following one. Byte order is checked in a similar way. Only the upper byte of a limit is rewritten, so that the reading crosses the limit, and then only the lower byte, so that it crosses back. Each flip must show in the flag bytes.

// File: rtl/dmon_pkg.sv
package dmon_pkg;
  localparam int unsigned CH_COUNT = 5;
  localparam int unsigned KINDS    = 4;

  localparam int unsigned CH_TEMP  = 0;
  localparam int unsigned CH_VCC   = 1;
  localparam int unsigned CH_BIAS  = 2;
  localparam int unsigned CH_TXPWR = 3;
  localparam int unsigned CH_RXPWR = 4;

  typedef enum logic [1:0] {
    K_HI_ALM = 2'd0,
    K_LO_ALM = 2'd1,
    K_HI_WRN = 2'd2,
    K_LO_WRN = 2'd3
  } lim_kind_e;

  // per-channel flag nibble positions
  localparam int unsigned F_HI_ALM = 3;
  localparam int unsigned F_LO_ALM = 2;
  localparam int unsigned F_HI_WRN = 1;
  localparam int unsigned F_LO_WRN = 0;
endpackage

// File: rtl/dmon_lim_bank.sv
module dmon_lim_bank
  import dmon_pkg::*;
#(
  parameter int unsigned NCH = CH_COUNT,
  parameter int unsigned DW  = 16,
  parameter int unsigned AW  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [7:0]              wr_byte,
  output logic [NCH*KINDS*DW-1:0] lim_flat
);
  localparam int unsigned BPV    = DW / 8;
  localparam int unsigned NVAL   = NCH * KINDS;
  localparam int unsigned NBYTES = NVAL * BPV;

  logic [7:0] mem [NBYTES];
  logic       addr_ok;

  assign addr_ok = (wr_addr < AW'(NBYTES));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
    end else if (wr_en && addr_ok) begin
      mem[wr_addr] <= wr_byte;
    end
  end

  // most significant byte sits at the lower address
  for (genvar v = 0; v < NVAL; v++) begin : g_val
    for (genvar b = 0; b < BPV; b++) begin : g_byte
      assign lim_flat[v*DW + DW-1 - 8*b -: 8] = mem[v*BPV + b];
    end
  end

  p_stray_write_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr_ok) |=> $stable(lim_flat));
endmodule

// File: rtl/dmon_chan_cmp.sv
module dmon_chan_cmp
  import dmon_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter bit          SIGNED = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [DW-1:0] reading,
  input  logic [DW-1:0] hi_alm,
  input  logic [DW-1:0] lo_alm,
  input  logic [DW-1:0] hi_wrn,
  input  logic [DW-1:0] lo_wrn,
  output logic [3:0]    flags_q
);
  logic gt_ha, lt_la, gt_hw, lt_lw;

  if (SIGNED) begin : g_signed
    assign gt_ha = $signed(reading) > $signed(hi_alm);
    assign lt_la = $signed(reading) < $signed(lo_alm);
    assign gt_hw = $signed(reading) > $signed(hi_wrn);
    assign lt_lw = $signed(reading) < $signed(lo_wrn);

    // negative reading can never exceed a non-negative upper alarm
    p_neg_below_pos_r5: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && reading[DW-1] && !hi_alm[DW-1]) |=> !flags_q[F_HI_ALM]);
  end else begin : g_unsigned
    assign gt_ha = reading > hi_alm;
    assign lt_la = reading < lo_alm;
    assign gt_hw = reading > hi_wrn;
    assign lt_lw = reading < lo_wrn;

    // top-bit reading beats any upper alarm without its top bit
    p_msb_above_r6: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && reading[DW-1] && !hi_alm[DW-1]) |=> flags_q[F_HI_ALM]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (smp_valid) begin
      flags_q[F_HI_ALM] <= gt_ha;
      flags_q[F_LO_ALM] <= lt_la;
      flags_q[F_HI_WRN] <= gt_hw;
      flags_q[F_LO_WRN] <= lt_lw;
    end
  end

  p_hold_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(flags_q));
endmodule

// File: rtl/dmon_flag_pack.sv
module dmon_flag_pack
  import dmon_pkg::*;
#(
  parameter int unsigned NCH = CH_COUNT
) (
  input  logic [NCH*4-1:0] ch_flags,
  output logic [7:0]       alm_b0,
  output logic [7:0]       alm_b1,
  output logic [7:0]       wrn_b0,
  output logic [7:0]       wrn_b1
);
  logic [15:0] alm16, wrn16;

  // channel c takes bit pair (15-2c, 14-2c) of the two-byte field
  always_comb begin
    alm16 = '0;
    wrn16 = '0;
    for (int c = 0; c < NCH; c++) begin
      alm16[15-2*c] = ch_flags[4*c + F_HI_ALM];
      alm16[14-2*c] = ch_flags[4*c + F_LO_ALM];
      wrn16[15-2*c] = ch_flags[4*c + F_HI_WRN];
      wrn16[14-2*c] = ch_flags[4*c + F_LO_WRN];
    end
  end

  assign alm_b0 = alm16[15:8];
  assign alm_b1 = alm16[7:0];
  assign wrn_b0 = wrn16[15:8];
  assign wrn_b1 = wrn16[7:0];
endmodule

// File: rtl/dmon_flag_gen.sv
module dmon_flag_gen
  import dmon_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lim_wr_en,
  input  logic [AW-1:0] lim_wr_addr,
  input  logic [7:0]    lim_wr_data,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_temp,
  input  logic [DW-1:0] smp_vcc,
  input  logic [DW-1:0] smp_bias,
  input  logic [DW-1:0] smp_txpwr,
  input  logic [DW-1:0] smp_rxpwr,
  output logic [7:0]    alarm_flags0,
  output logic [7:0]    alarm_flags1,
  output logic [7:0]    warn_flags0,
  output logic [7:0]    warn_flags1
);
  localparam int unsigned NCH = CH_COUNT;

  logic [NCH*KINDS*DW-1:0] lim_flat;
  logic [DW-1:0]           rd [NCH];
  logic [NCH*4-1:0]        ch_flags;

  assign rd[CH_TEMP]  = smp_temp;
  assign rd[CH_VCC]   = smp_vcc;
  assign rd[CH_BIAS]  = smp_bias;
  assign rd[CH_TXPWR] = smp_txpwr;
  assign rd[CH_RXPWR] = smp_rxpwr;

  dmon_lim_bank #(.NCH(NCH), .DW(DW), .AW(AW)) lim_bank_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (lim_wr_en),
    .wr_addr  (lim_wr_addr),
    .wr_byte  (lim_wr_data),
    .lim_flat (lim_flat)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned BASE = c * KINDS * DW;
    dmon_chan_cmp #(.DW(DW), .SIGNED(c == CH_TEMP)) cmp_i (
      .clk       (clk),
      .rst       (rst),
      .smp_valid (smp_valid),
      .reading   (rd[c]),
      .hi_alm    (lim_flat[BASE + int'(K_HI_ALM)*DW +: DW]),
      .lo_alm    (lim_flat[BASE + int'(K_LO_ALM)*DW +: DW]),
      .hi_wrn    (lim_flat[BASE + int'(K_HI_WRN)*DW +: DW]),
      .lo_wrn    (lim_flat[BASE + int'(K_LO_WRN)*DW +: DW]),
      .flags_q   (ch_flags[4*c +: 4])
    );
  end

  dmon_flag_pack #(.NCH(NCH)) pack_i (
    .ch_flags (ch_flags),
    .alm_b0   (alarm_flags0),
    .alm_b1   (alarm_flags1),
    .wrn_b0   (warn_flags0),
    .wrn_b1   (warn_flags1)
  );

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (alarm_flags0 == 8'h00 && alarm_flags1 == 8'h00 &&
                    warn_flags0 == 8'h00 && warn_flags1 == 8'h00));

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (alarm_flags1[5:0] == 6'd0) && (warn_flags1[5:0] == 6'd0));
endmodule

// File: tb/dmon_flag_gen_tb.sv
`timescale 1ns/1ps
module dmon_flag_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lim_wr_en = 1'b0;
  logic [5:0]  lim_wr_addr = '0;
  logic [7:0]  lim_wr_data = '0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_temp = '0, smp_vcc = '0, smp_bias = '0, smp_txpwr = '0, smp_rxpwr = '0;
  logic [7:0]  alarm_flags0, alarm_flags1, warn_flags0, warn_flags1;

  int tests = 0;
  int fails = 0;
  logic [7:0] lim_b [40];

  always #4 clk = ~clk;

  dmon_flag_gen dut_i (
    .clk(clk), .rst(rst),
    .lim_wr_en(lim_wr_en), .lim_wr_addr(lim_wr_addr), .lim_wr_data(lim_wr_data),
    .smp_valid(smp_valid), .smp_temp(smp_temp), .smp_vcc(smp_vcc),
    .smp_bias(smp_bias), .smp_txpwr(smp_txpwr), .smp_rxpwr(smp_rxpwr),
    .alarm_flags0(alarm_flags0), .alarm_flags1(alarm_flags1),
    .warn_flags0(warn_flags0), .warn_flags1(warn_flags1)
  );

  function automatic logic [15:0] lim(input int c, input int k);
    return {lim_b[8*c + 2*k], lim_b[8*c + 2*k + 1]};
  endfunction

  function automatic bit above(input int c, input logic [15:0] r, input logic [15:0] t);
    if (c == 0) return $signed(r) > $signed(t);
    return r > t;
  endfunction

  // returns {alarm0, alarm1, warn0, warn1}
  function automatic logic [31:0] model(input logic [15:0] r0, r1, r2, r3, r4);
    logic [15:0] r [5];
    logic [15:0] a, w;
    r[0] = r0; r[1] = r1; r[2] = r2; r[3] = r3; r[4] = r4;
    a = '0; w = '0;
    for (int c = 0; c < 5; c++) begin
      a[15-2*c] = above(c, r[c], lim(c, 0));
      a[14-2*c] = above(c, lim(c, 1), r[c]);
      w[15-2*c] = above(c, r[c], lim(c, 2));
      w[14-2*c] = above(c, lim(c, 3), r[c]);
    end
    return {a, w};
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    logic [31:0] got;
    got = {alarm_flags0, alarm_flags1, warn_flags0, warn_flags1};
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_byte(input int addr, input logic [7:0] d);
    @(negedge clk);
    lim_wr_en = 1'b1; lim_wr_addr = 6'(addr); lim_wr_data = d;
    @(negedge clk);
    lim_wr_en = 1'b0;
    if (addr < 40) lim_b[addr] = d;
  endtask

  task automatic wr_lim(input int c, input int k, input logic [15:0] v);
    wr_byte(8*c + 2*k, v[15:8]);
    wr_byte(8*c + 2*k + 1, v[7:0]);
  endtask

  task automatic strobe(input logic [15:0] t, v, b, tp, rp);
    @(negedge clk);
    smp_temp = t; smp_vcc = v; smp_bias = b; smp_txpwr = tp; smp_rxpwr = rp;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  localparam logic [15:0] NT = 16'h1900, NV = 16'h80E8, NB = 16'h1770,
                          NTX = 16'h0FA0, NRX = 16'h07D0;

  task automatic t_reset;
    check("R1 flags after reset", 32'h0);
  endtask

  task automatic t_program;
    wr_lim(0, 0, 16'h5500); wr_lim(0, 1, 16'hEC00); wr_lim(0, 2, 16'h5000); wr_lim(0, 3, 16'hF600);
    wr_lim(1, 0, 16'h9088); wr_lim(1, 1, 16'h7148); wr_lim(1, 2, 16'h8CA0); wr_lim(1, 3, 16'h7530);
    wr_lim(2, 0, 16'h3A98); wr_lim(2, 1, 16'h03E8); wr_lim(2, 2, 16'h2EE0); wr_lim(2, 3, 16'h07D0);
    wr_lim(3, 0, 16'h2710); wr_lim(3, 1, 16'h03E8); wr_lim(3, 2, 16'h1F40); wr_lim(3, 3, 16'h05DC);
    wr_lim(4, 0, 16'h2710); wr_lim(4, 1, 16'h0064); wr_lim(4, 2, 16'h1F40); wr_lim(4, 3, 16'h00C8);
    strobe(NT, NV, NB, NTX, NRX);
    check("R3 R4 nominal in range", 32'h0);
  endtask

  task automatic t_strict;
    // equal to upper alarm: only upper warnings
    strobe(16'h5500, 16'h9088, 16'h3A98, 16'h2710, 16'h2710);
    check("R3 equal to upper alarm", model(16'h5500, 16'h9088, 16'h3A98, 16'h2710, 16'h2710));
    check("R3 equal explicit", {16'h0000, 16'hAA80});
    // equal to lower alarm: only lower warnings
    strobe(16'hEC00, 16'h7148, 16'h03E8, 16'h03E8, 16'h0064);
    check("R4 equal to lower alarm", {16'h0000, 16'h5540});
    strobe(16'hEBFF, 16'h7147, 16'h03E7, 16'h03E7, 16'h0063);
    check("R4 one below lower alarm", {16'h5540, 16'h5540});
  endtask

  task automatic t_signed;
    strobe(16'hFF00, NV, NB, NTX, NRX);
    check("R5 temp -1 degree no flag", 32'h0);
    strobe(16'hF000, NV, NB, NTX, NRX);
    check("R5 temp -16 lower warning", {16'h0000, 16'h4000});
    strobe(16'h8000, NV, NB, NTX, NRX);
    check("R5 most negative temp", {16'h4000, 16'h4000});
  endtask

  task automatic t_unsigned;
    strobe(NT, 16'hFF00, NB, NTX, NRX);
    check("R6 vcc top bit high", {16'h2000, 16'h2000});
    strobe(NT, NV, 16'hFF00, 16'hFF00, 16'hFF00);
    check("R6 bias/txpwr/rxpwr top bit", {16'h0A80, 16'h0A80});
  endtask

  task automatic t_bitmap;
    logic [15:0] r [5];
    for (int c = 0; c < 5; c++) begin
      r[0] = NT; r[1] = NV; r[2] = NB; r[3] = NTX; r[4] = NRX;
      r[c] = lim(c, 0) + 16'd1;
      strobe(r[0], r[1], r[2], r[3], r[4]);
      check($sformatf("R7 R8 R9 upper bit ch%0d", c), {16'h8000 >> (2*c), 16'h8000 >> (2*c)});
      r[c] = lim(c, 1) - 16'd1;
      strobe(r[0], r[1], r[2], r[3], r[4]);
      check($sformatf("R7 R8 R9 lower bit ch%0d", c), {16'h4000 >> (2*c), 16'h4000 >> (2*c)});
    end
  endtask

  task automatic t_hold;
    strobe(16'hE000, NV, NB, NTX, NRX);
    check("R10 flagged state", {16'h4000, 16'h4000});
    @(negedge clk);
    smp_temp = NT; smp_vcc = 16'hFFFF; smp_rxpwr = 16'h0000;
    repeat (5) @(negedge clk);
    check("R10 hold without strobe", {16'h4000, 16'h4000});
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    smp_temp = 16'h3000; smp_vcc = NV; smp_bias = NB; smp_txpwr = NTX; smp_rxpwr = NRX;
    smp_valid = 1'b1;
    lim_wr_en = 1'b1; lim_wr_addr = 6'd0; lim_wr_data = 8'h20;
    @(negedge clk);
    smp_valid = 1'b0; lim_wr_en = 1'b0;
    check("R11 same-cycle write uses old limit", 32'h0);
    lim_b[0] = 8'h20;
    strobe(16'h3000, NV, NB, NTX, NRX);
    check("R11 next strobe uses new limit", {16'h8000, 16'h0000});
    wr_byte(0, 8'h55);
  endtask

  task automatic t_addr;
    for (int a = 40; a < 64; a++) wr_byte(a, 8'h00);
    strobe(NT, NV, NB, NTX, NRX);
    check("R2 stray addresses ignored", 32'h0);
    strobe(16'hEBFF, NV, 16'hFF00, NTX, 16'h0000);
    check("R2 stray addresses ignored, flagged", model(16'hEBFF, NV, 16'hFF00, NTX, 16'h0000));
    wr_byte(8, 8'h80);   // vcc upper alarm -> 0x8088
    strobe(NT, NV, NB, NTX, NRX);
    check("R2 msb byte at even address", {16'h2000, 16'h0000});
    wr_byte(9, 8'hFF);   // vcc upper alarm -> 0x80FF
    strobe(NT, NV, NB, NTX, NRX);
    check("R2 lsb byte at odd address", 32'h0);
  endtask

  task automatic t_reset_again;
    strobe(16'hE000, 16'hFF00, NB, NTX, 16'h0000);
    check("R1 flagged before reset", model(16'hE000, 16'hFF00, NB, NTX, 16'h0000));
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check("R1 reset clears flags", 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 40; i++) lim_b[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program();
    t_strict();
    t_signed();
    t_unsigned();
    t_bitmap();
    t_hold();
    t_same_cycle();
    t_addr();
    t_reset_again();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule